// File: doc/BRIEF.md
# Video DRAM Access-Cycle Capture and Classifier

This block is the front end of a multiport video DRAM model. It watches the asynchronous row and column strobes, resamples them on a system clock, and finds their edges. When the row strobe falls, it stores the multiplexed address as the row. At the same moment it records the control pins: the two byte write enables, the transfer enable, the special-function input and the level of the column strobe. From that record it assigns the access one of seven cycle types.

A later column-strobe fall inside the cycle stores the address as the column. A cycle that starts with a write enable low also carries a per-byte write-mask enable, with the mask value taken from the data pins. All results stay fixed until the row strobe rises. The block then issues a one-cycle end pulse and returns to idle. A column-strobe pulse that completes without a row strobe between its edges is flagged as a protocol error.

Top module: `vram_cycle_decode`

## Requirements
- R1: After reset, row_o, col_o, mask_o and mask_en_o are 0, and cyc_type_o is 0 (none). col_valid_o, cyc_active_o, cyc_end_o and proto_err_o are all low.
- R2: On a row-strobe fall, cyc_active_o goes high and row_o takes addr_i. row_o then holds while the cycle stays active.
- R3: If the column strobe is already low at the row-strobe fall, the cycle is a column-before-row cycle. cyc_type_o is 5 (option reset) when sf_i was 1, else 4 (refresh). This test has priority over R4 and R5.
- R4: Otherwise, if xfer_n_i was low, the cycle is a transfer. cyc_type_o is 3 (split transfer) when sf_i was 1, else 2 (full transfer).
- R5: Otherwise the cycle is a DRAM cycle. cyc_type_o is 1 (read/write) when sf_i was 0. With sf_i 1 it is 6 (block write) when either write enable was low, or 7 (register load) when both were high.
- R6: A column-strobe fall during an active cycle sets col_o to addr_i and raises col_valid_o. In a split transfer, col_o bit 7 is forced to 0.
- R7: In a DRAM cycle, mask_en_o[0] is the inverse of we_lo_n_i and mask_en_o[1] is the inverse of we_hi_n_i, both sampled at the row-strobe fall. mask_o takes dq_i in a DRAM cycle. In other cycles both are 0.
- R8: On a row-strobe rise during an active cycle, cyc_end_o pulses high for exactly one clock. In the same clock cyc_active_o, col_valid_o, cyc_type_o and mask_en_o clear, while row_o and col_o keep their values.
- R9: A column-strobe fall outside an active cycle does not change col_o. If the column strobe then rises with no row-strobe fall in between, proto_err_o pulses for one clock.
- R10: An output reacts to a strobe change on the third rising clock edge after the change: two synchronizer stages plus one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_lo_n_i | input | 1 | Low-byte write enable, active low |
| we_hi_n_i | input | 1 | High-byte write enable, active low |
| xfer_n_i | input | 1 | Transfer enable, active low |
| sf_i | input | 1 | Special-function select |
| addr_i | input | 9 | Multiplexed row/column address |
| dq_i | input | 16 | Data pins, source of the write mask |
| row_o | output | 9 | Latched row address |
| col_o | output | 9 | Latched column address |
| col_valid_o | output | 1 | Column latched in current cycle |
| cyc_active_o | output | 1 | A cycle is in progress |
| cyc_type_o | output | 3 | Cycle type code (R3 to R5) |
| mask_en_o | output | 2 | Per-byte write-mask enable |
| mask_o | output | 16 | Write-mask value |
| cyc_end_o | output | 1 | One-clock pulse at cycle end |
| proto_err_o | output | 1 | One-clock pulse on a stray column strobe |

## Verification
A wrong cycle code or mask latch shows up on cyc_type_o and mask_en_o on the third clock after the row strobe falls, and stays visible for the whole cycle. A broken end or idle state shows up on the third clock after the row strobe rises: either cyc_end_o fails to pulse, or cyc_type_o fails to return to 0. A stuck arm for a column strobe without a row strobe surfaces as a missing or spurious proto_err_o pulse three clocks after the column strobe rises. Every one of the 32 control combinations is swept, so each code path is reached.

// File: rtl/vram_pkg.sv
package vram_pkg;
  typedef enum logic [2:0] {
    CYC_NONE       = 3'd0,
    CYC_RW         = 3'd1,
    CYC_FULL_XFER  = 3'd2,
    CYC_SPLIT_XFER = 3'd3,
    CYC_REFRESH    = 3'd4,
    CYC_OPT_RESET  = 3'd5,
    CYC_BLOCK_WR   = 3'd6,
    CYC_REG_LOAD   = 3'd7
  } cyc_type_e;
endpackage

// File: rtl/vram_delay_line.sv
module vram_delay_line #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[i] <= {W{RST_VAL}};
        else         stg[i] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[i] <= {W{RST_VAL}};
        else         stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/vram_strobe_edge.sv
module vram_strobe_edge #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] strobe_n_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  vram_delay_line #(.W(W), .STAGES(STAGES), .RST_VAL(1'b1)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (strobe_n_i),
    .q_o   (lvl_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= {W{1'b1}};
    else         prev_q <= lvl_o;

  assign fall_o = prev_q & ~lvl_o;
  assign rise_o = ~prev_q & lvl_o;
endmodule

// File: rtl/vram_cycle_classify.sv
module vram_cycle_classify
  import vram_pkg::*;
(
  input  logic      cas_n_i,
  input  logic      xfer_n_i,
  input  logic      we_lo_n_i,
  input  logic      we_hi_n_i,
  input  logic      sf_i,
  output cyc_type_e type_o,
  output logic      dram_o,
  output logic [1:0] mask_en_o
);
  always_comb begin
    dram_o = 1'b0;
    if (!cas_n_i)       type_o = sf_i ? CYC_OPT_RESET : CYC_REFRESH;
    else if (!xfer_n_i) type_o = sf_i ? CYC_SPLIT_XFER : CYC_FULL_XFER;
    else begin
      dram_o = 1'b1;
      if (!sf_i)                    type_o = CYC_RW;
      else if (we_lo_n_i && we_hi_n_i) type_o = CYC_REG_LOAD;
      else                          type_o = CYC_BLOCK_WR;
    end
    mask_en_o = dram_o ? {~we_hi_n_i, ~we_lo_n_i} : 2'b00;
  end
endmodule

// File: rtl/vram_cycle_decode.sv
module vram_cycle_decode
  import vram_pkg::*;
#(
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned DQ_W        = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_n_i,
  input  logic              cas_n_i,
  input  logic              we_lo_n_i,
  input  logic              we_hi_n_i,
  input  logic              xfer_n_i,
  input  logic              sf_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DQ_W-1:0]   dq_i,
  output logic [ADDR_W-1:0] row_o,
  output logic [ADDR_W-1:0] col_o,
  output logic              col_valid_o,
  output logic              cyc_active_o,
  output logic [2:0]        cyc_type_o,
  output logic [1:0]        mask_en_o,
  output logic [DQ_W-1:0]   mask_o,
  output logic              cyc_end_o,
  output logic              proto_err_o
);
  localparam int unsigned BUS_W   = ADDR_W + DQ_W + 4;
  localparam int unsigned SPLIT_B = ADDR_W - 2;

  logic [BUS_W-1:0]  bus_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DQ_W-1:0]   dq_d;
  logic              sf_d, xfer_n_d, we_hi_n_d, we_lo_n_d;
  logic [1:0]        lvl, fall, rise;
  logic              ras_fall, ras_rise, cas_fall, cas_rise, cas_lvl;

  // data aligned with synchronized strobes
  vram_delay_line #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_bus_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sf_i, xfer_n_i, we_hi_n_i, we_lo_n_i, dq_i, addr_i}),
    .q_o   (bus_d)
  );
  assign {sf_d, xfer_n_d, we_hi_n_d, we_lo_n_d, dq_d, addr_d} = bus_d;

  vram_strobe_edge #(.W(2), .STAGES(SYNC_STAGES)) i_strobe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_n_i({cas_n_i, ras_n_i}),
    .lvl_o     (lvl),
    .fall_o    (fall),
    .rise_o    (rise)
  );
  assign ras_fall = fall[0];
  assign ras_rise = rise[0];
  assign cas_fall = fall[1];
  assign cas_rise = rise[1];
  assign cas_lvl  = lvl[1];

  cyc_type_e  cls_type;
  logic       cls_dram;
  logic [1:0] cls_mask_en;

  vram_cycle_classify i_cls (
    .cas_n_i  (cas_lvl),
    .xfer_n_i (xfer_n_d),
    .we_lo_n_i(we_lo_n_d),
    .we_hi_n_i(we_hi_n_d),
    .sf_i     (sf_d),
    .type_o   (cls_type),
    .dram_o   (cls_dram),
    .mask_en_o(cls_mask_en)
  );

  cyc_type_e         type_q;
  logic [ADDR_W-1:0] row_q, col_q;
  logic [DQ_W-1:0]   mask_q;
  logic [1:0]        mask_en_q;
  logic              active_q, col_valid_q, end_q, err_q, arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q      <= CYC_NONE;
      row_q       <= '0;
      col_q       <= '0;
      mask_q      <= '0;
      mask_en_q   <= '0;
      active_q    <= 1'b0;
      col_valid_q <= 1'b0;
      end_q       <= 1'b0;
      err_q       <= 1'b0;
      arm_q       <= 1'b0;
    end else begin
      end_q <= 1'b0;
      err_q <= 1'b0;
      if (ras_fall) begin
        active_q    <= 1'b1;
        row_q       <= addr_d;
        type_q      <= cls_type;
        col_valid_q <= 1'b0;
        mask_en_q   <= cls_mask_en;
        mask_q      <= cls_dram ? dq_d : '0;
        arm_q       <= 1'b0;
      end else if (ras_rise && active_q) begin
        active_q    <= 1'b0;
        type_q      <= CYC_NONE;
        col_valid_q <= 1'b0;
        mask_en_q   <= '0;
        end_q       <= 1'b1;
      end
      if (cas_fall && !ras_fall) begin
        if (active_q) begin
          col_q       <= addr_d;
          if (type_q == CYC_SPLIT_XFER) col_q[SPLIT_B] <= 1'b0;
          col_valid_q <= 1'b1;
        end else begin
          arm_q <= 1'b1;  // may still become column-before-row
        end
      end
      if (cas_rise && arm_q && !ras_fall) begin
        err_q <= 1'b1;
        arm_q <= 1'b0;
      end
    end
  end

  assign row_o        = row_q;
  assign col_o        = col_q;
  assign col_valid_o  = col_valid_q;
  assign cyc_active_o = active_q;
  assign cyc_type_o   = type_q;
  assign mask_en_o    = mask_en_q;
  assign mask_o       = mask_q;
  assign cyc_end_o    = end_q;
  assign proto_err_o  = err_q;
endmodule

// File: rtl/vram_cycle_chk.sv
module vram_cycle_chk #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DQ_W   = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] row_o,
  input logic [ADDR_W-1:0] col_o,
  input logic              col_valid_o,
  input logic              cyc_active_o,
  input logic [2:0]        cyc_type_o,
  input logic [1:0]        mask_en_o,
  input logic              cyc_end_o,
  input logic              proto_err_o
);
  // R8
  end_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_end_o |-> !cyc_active_o ##1 !cyc_end_o);
  // R8
  idle_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_active_o |-> (cyc_type_o == 3'd0) && !col_valid_o && (mask_en_o == 2'b00));
  // R2
  row_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_active_o && $past(cyc_active_o) |-> $stable(row_o));
  // R7
  mask_dram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_en_o != 2'b00) |-> (cyc_type_o == 3'd1 || cyc_type_o == 3'd6));
  // R6
  split_tap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_valid_o && (cyc_type_o == 3'd3) |-> !col_o[ADDR_W-2]);
  // R9
  stray_cas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> !cyc_active_o && $stable(col_o) ##1 !proto_err_o);
endmodule

bind vram_cycle_decode vram_cycle_chk #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) i_chk (.*);

// File: tb/test_vram_cycle_decode.sv
module test_vram_cycle_decode;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        ras_n_i = 1'b1, cas_n_i = 1'b1;
  logic        we_lo_n_i = 1'b1, we_hi_n_i = 1'b1, xfer_n_i = 1'b1, sf_i = 1'b0;
  logic [8:0]  addr_i = '0;
  logic [15:0] dq_i = '0;
  logic [8:0]  row_o, col_o;
  logic        col_valid_o, cyc_active_o, cyc_end_o, proto_err_o;
  logic [2:0]  cyc_type_o;
  logic [1:0]  mask_en_o;
  logic [15:0] mask_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  vram_cycle_decode i_vram_cycle_decode (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic int exp_type(bit cbr, bit xn, bit wl, bit wh, bit sf);
    if (cbr)     return sf ? 5 : 4;
    if (!xn)     return sf ? 3 : 2;
    if (!sf)     return 1;
    return (wl && wh) ? 7 : 6;
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int last_col;
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(2);
    // R1
    chk(row_o == 0 && col_o == 0 && mask_o == 0 && mask_en_o == 0, "R1 regs", row_o, 0);
    chk(cyc_type_o == 0 && !cyc_active_o && !col_valid_o, "R1 type", cyc_type_o, 0);
    chk(!cyc_end_o && !proto_err_o, "R1 pulses", {cyc_end_o, proto_err_o}, 0);
    last_col = 0;

    for (int c = 0; c < 32; c++) begin
      bit sf, wl, wh, xn, cbr, dram;
      int row, col, et, dq;
      sf = c[0]; wl = c[1]; wh = c[2]; xn = c[3]; cbr = c[4];
      row = (c * 13 + 5) % 512;
      col = (c * 37 + 200) % 512;
      dq  = (c * 16'h0911) ^ 16'hA5C3;
      et  = exp_type(cbr, xn, wl, wh, sf);
      dram = !cbr && xn;

      sf_i = sf; we_lo_n_i = wl; we_hi_n_i = wh; xfer_n_i = xn;
      addr_i = row[8:0]; dq_i = dq[15:0];
      if (cbr) begin
        cas_n_i = 1'b0;
        wait_n(5);
        chk(!proto_err_o && col_o == last_col[8:0], "R9 cbr no err", proto_err_o, 0);
      end
      ras_n_i = 1'b0;
      wait_n(2);
      // R10: not yet visible after two edges
      chk(!cyc_active_o, "R10 early", cyc_active_o, 0);
      wait_n(1);
      chk(cyc_active_o && row_o == row[8:0], "R2 row", row_o, row);
      if (cbr) chk(cyc_type_o == et, "R3 cbr type", cyc_type_o, et);
      else if (!xn) chk(cyc_type_o == et, "R4 xfer type", cyc_type_o, et);
      else chk(cyc_type_o == et, "R5 dram type", cyc_type_o, et);
      chk(mask_en_o == (dram ? {~wh, ~wl} : 2'b00), "R7 mask en", mask_en_o,
          dram ? {~wh, ~wl} : 0);
      chk(mask_o == (dram ? dq[15:0] : 16'h0), "R7 mask val", mask_o, dram ? dq : 0);

      if (!cbr) begin
        int ecol;
        addr_i = col[8:0];
        dq_i = ~dq_i;
        cas_n_i = 1'b0;
        wait_n(3);
        ecol = (et == 3) ? (col & ~(1 << 7)) : col;
        chk(col_valid_o && col_o == ecol[8:0], "R6 col", col_o, ecol);
        chk(row_o == row[8:0], "R2 row hold", row_o, row);
        last_col = ecol;
        cas_n_i = 1'b1;
        wait_n(3);
        chk(!proto_err_o, "R9 normal cas rise", proto_err_o, 0);
      end else begin
        chk(!col_valid_o, "R6 cbr no col", col_valid_o, 0);
      end

      ras_n_i = 1'b1;
      cas_n_i = 1'b1;
      wait_n(3);
      chk(cyc_end_o && !cyc_active_o && cyc_type_o == 0, "R8 end", {cyc_end_o, cyc_type_o}, 8);
      chk(!col_valid_o && mask_en_o == 0, "R8 clear", {col_valid_o, mask_en_o}, 0);
      wait_n(1);
      chk(!cyc_end_o, "R8 one pulse", cyc_end_o, 0);
      chk(row_o == row[8:0] && col_o == last_col[8:0], "R8 hold", col_o, last_col);

      if (c % 4 == 3) begin
        // R9 stray column strobe
        addr_i = 9'h1FF ^ col[8:0];
        cas_n_i = 1'b0;
        wait_n(4);
        chk(col_o == last_col[8:0] && !col_valid_o, "R9 ignored", col_o, last_col);
        cas_n_i = 1'b1;
        wait_n(2);
        chk(!proto_err_o, "R9 early", proto_err_o, 0);
        wait_n(1);
        chk(proto_err_o, "R9 err pulse", proto_err_o, 1);
        wait_n(1);
        chk(!proto_err_o && col_o == last_col[8:0], "R9 err end", proto_err_o, 0);
      end
      wait_n(2);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule